// File: doc/BRIEF.md
# Addressed Three-Wire Register Loader

This block takes configuration words from a three-wire serial port and puts each one into one of four internal registers. The port has a serial clock, a serial data line and a load-enable line. All three pins are asynchronous to the system clock. Each pin passes through a two-flop synchroniser and then a level filter. The filter accepts a new level only after it has held for `FILT` system cycles, so pulses shorter than that never reach the shift logic. Every accepted rising edge of the serial clock shifts the filtered data bit into a 24-bit shift register, most significant bit first.

When the filtered load-enable rises, the block checks how many bits arrived since the previous load. If exactly 24 bits arrived, the two bits received last form a register address. The 22 bits in front of them become that register's new contents, and that register's update strobe pulses for one cycle. If any other number of bits arrived, no register changes and an error strobe pulses instead. In both cases the bit count restarts. Downstream logic reads the four register words in parallel and uses the strobes to see when a register has changed.

Top module: `twl_reg_loader`

## Requirements
- R1: Synchronous reset (`rst` high) clears all four register words, the update strobes and the error strobe to zero.
- R2: A frame is 24 bits, shifted in MSB first on accepted rising edges of `ser_clk_i`. Frame bit 1 (the second-to-last bit received) and bit 0 (the last bit received) form the register index, `{bit1,bit0}`. Frame bits 23..2 are stored as the 22-bit word of that index, which appears on `reg_words_o[idx*22 +: 22]`.
- R3: A load changes only the addressed register word. The other three keep their values.
- R4: A successful load pulses `reg_upd_o[idx]` high for exactly one cycle, in the same cycle that the new word first appears. This is the cycle after the (FILT+3)-th rising system-clock edge that samples `ser_le_i` high.
- R5: Each rising edge of the load-enable causes exactly one load, however long the line stays high. A falling edge causes no load.
- R6: If the bit count at a load-enable rise is not 24 (fewer or more), no register changes and `frame_err_o` pulses for one cycle, with the same timing as R4.
- R7: Every accepted load-enable rise restarts the bit count, so a correct frame sent after a rejected frame loads normally.
- R8: A level on any serial pin that lasts fewer than FILT system cycles is ignored. A short pulse on the serial clock shifts no bit, and a short pulse on the load-enable causes no load and does not restart the bit count.
- R9: At most one update strobe is high in any cycle, and no update strobe is high in the same cycle as `frame_err_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk_i | input | 1 | Asynchronous serial clock pin |
| ser_data_i | input | 1 | Asynchronous serial data pin |
| ser_le_i | input | 1 | Asynchronous load-enable pin |
| reg_words_o | output | 88 | Four 22-bit register words; word i sits at bits i*22 +: 22 |
| reg_upd_o | output | 4 | One-cycle update strobe for each register |
| frame_err_o | output | 1 | One-cycle strobe for a frame with a wrong bit count |

## Verification
The assertions take four things for granted. Each intended serial level lasts at least FILT+1 system cycles. The data line is stable across the filtered rise of the serial clock. The serial clock is low and idle for several cycles around each load-enable rise. Reset is held for at least one clock edge. The stimulus meets these conditions by holding every serial level for three system cycles or more. It changes data only while the serial clock is low, and it spaces load-enable pulses well clear of the last clock fall. The only pulses shorter than FILT cycles are the single-cycle glitches that are injected on purpose to exercise R8.

// File: rtl/twl_pkg.sv
package twl_pkg;
    parameter int FRAME_W = 24;
    parameter int ADDR_W  = 2;
    localparam int NUM_REGS  = 1 << ADDR_W;
    localparam int PAYLOAD_W = FRAME_W - ADDR_W;
    localparam int CNT_W     = $clog2(FRAME_W + 2);

    // address in the last-received bits, payload above it
    typedef struct packed {
        logic [PAYLOAD_W-1:0] payload;
        logic [ADDR_W-1:0]    addr;
    } frame_s;

    typedef struct packed {
        logic   load;
        logic   err;
        frame_s frame;
    } xfer_s;

    function automatic logic [NUM_REGS-1:0] addr_select(input logic [ADDR_W-1:0] a);
        return NUM_REGS'(1) << a;
    endfunction
endpackage

// File: rtl/twl_line_filter.sv
module twl_line_filter #(
    parameter int W    = 3,
    parameter int FILT = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] pin_i,
    output logic [W-1:0] level_o
);
    localparam int CW = (FILT > 1) ? $clog2(FILT) : 1;

    logic [W-1:0] ff1_q, ff2_q, acc_q;

    for (genvar i = 0; i < W; i++) begin : g_line
        logic [CW-1:0] cnt_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                ff1_q[i] <= 1'b0;
                ff2_q[i] <= 1'b0;
                acc_q[i] <= 1'b0;
                cnt_q    <= '0;
            end else begin
                ff1_q[i] <= pin_i[i];
                ff2_q[i] <= ff1_q[i];
                if (ff2_q[i] == acc_q[i]) begin
                    cnt_q <= '0;
                end else if (cnt_q == CW'(FILT - 1)) begin
                    acc_q[i] <= ff2_q[i];
                    cnt_q    <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end

        // R8: an accepted level must have been present at the synchroniser output
        p_rise_backed_r8: assert property (@(posedge clk) disable iff (rst)
            $rose(acc_q[i]) |-> $past(ff2_q[i]));
        p_fall_backed_r8: assert property (@(posedge clk) disable iff (rst)
            $fell(acc_q[i]) |-> !$past(ff2_q[i]));
    end

    assign level_o = acc_q;
endmodule

// File: rtl/twl_shifter.sv
module twl_shifter
    import twl_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  sclk_i,
    input  logic  sdata_i,
    input  logic  le_i,
    output xfer_s xfer_o
);
    logic               sclk_q, le_q;
    logic [FRAME_W-1:0] shreg_q;
    logic [CNT_W-1:0]   cnt_q;
    logic               sclk_rise, le_rise, full;

    assign sclk_rise = sclk_i & ~sclk_q;
    assign le_rise   = le_i & ~le_q;
    assign full      = (cnt_q == CNT_W'(FRAME_W));

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q  <= 1'b0;
            le_q    <= 1'b0;
            shreg_q <= '0;
            cnt_q   <= '0;
        end else begin
            sclk_q <= sclk_i;
            le_q   <= le_i;
            if (le_rise) begin
                cnt_q <= '0;
            end else if (sclk_rise) begin
                shreg_q <= {shreg_q[FRAME_W-2:0], sdata_i};
                if (cnt_q != CNT_W'(FRAME_W + 1))
                    cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    always_comb begin
        xfer_o.load  = le_rise & full;
        xfer_o.err   = le_rise & ~full;
        xfer_o.frame = frame_s'(shreg_q);
    end

    p_cnt_bound_r6: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_W'(FRAME_W + 1));
    p_cnt_restart_r7: assert property (@(posedge clk) disable iff (rst)
        le_rise |=> (cnt_q == '0));
endmodule

// File: rtl/twl_latch_bank.sv
module twl_latch_bank
    import twl_pkg::*;
(
    input  logic                            clk,
    input  logic                            rst,
    input  xfer_s                           xfer_i,
    output logic [NUM_REGS*PAYLOAD_W-1:0]   words_o,
    output logic [NUM_REGS-1:0]             upd_o,
    output logic                            err_o
);
    logic [NUM_REGS-1:0] sel;
    assign sel = addr_select(xfer_i.frame.addr);

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        logic [PAYLOAD_W-1:0] word_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                word_q   <= '0;
                upd_o[i] <= 1'b0;
            end else begin
                upd_o[i] <= xfer_i.load & sel[i];
                if (xfer_i.load && sel[i])
                    word_q <= xfer_i.frame.payload;
            end
        end
        assign words_o[i*PAYLOAD_W +: PAYLOAD_W] = word_q;
    end

    always_ff @(posedge clk) begin
        if (rst) err_o <= 1'b0;
        else     err_o <= xfer_i.err;
    end

    p_one_upd_r9: assert property (@(posedge clk) disable iff (rst)
        $onehot0(upd_o));
    p_upd_err_excl_r9: assert property (@(posedge clk) disable iff (rst)
        !(err_o && (|upd_o)));
    p_upd_single_r4: assert property (@(posedge clk) disable iff (rst)
        (|upd_o) |=> !(|upd_o));
endmodule

// File: rtl/twl_reg_loader.sv
module twl_reg_loader
    import twl_pkg::*;
#(
    parameter int FILT = 2
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          ser_clk_i,
    input  logic                          ser_data_i,
    input  logic                          ser_le_i,
    output logic [NUM_REGS*PAYLOAD_W-1:0] reg_words_o,
    output logic [NUM_REGS-1:0]           reg_upd_o,
    output logic                          frame_err_o
);
    logic [2:0] lvl;
    xfer_s      xfer;

    twl_line_filter #(.W(3), .FILT(FILT)) u_filt (
        .clk     (clk),
        .rst     (rst),
        .pin_i   ({ser_le_i, ser_data_i, ser_clk_i}),
        .level_o (lvl)
    );

    twl_shifter u_shift (
        .clk     (clk),
        .rst     (rst),
        .sclk_i  (lvl[0]),
        .sdata_i (lvl[1]),
        .le_i    (lvl[2]),
        .xfer_o  (xfer)
    );

    twl_latch_bank u_bank (
        .clk     (clk),
        .rst     (rst),
        .xfer_i  (xfer),
        .words_o (reg_words_o),
        .upd_o   (reg_upd_o),
        .err_o   (frame_err_o)
    );

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_chk
        // R3: a word moves only together with its own strobe
        p_word_needs_upd_r3: assert property (@(posedge clk) disable iff (rst)
            !$stable(reg_words_o[i*PAYLOAD_W +: PAYLOAD_W]) |-> reg_upd_o[i]);
    end

    p_err_keeps_words_r6: assert property (@(posedge clk) disable iff (rst)
        frame_err_o |-> $stable(reg_words_o));
endmodule

// File: tb/twl_reg_loader_tb_top.sv
module twl_reg_loader_tb_top;
    import twl_pkg::*;

    localparam int CLK_P = 10;
    localparam int FILT  = 2;
    localparam int HP    = 3;
    localparam int PW    = PAYLOAD_W;
    localparam int NR    = NUM_REGS;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ser_clk = 1'b0, ser_data = 1'b0, ser_le = 1'b0;
    logic [NR*PW-1:0] words;
    logic [NR-1:0]    upd;
    logic             err;

    twl_reg_loader #(.FILT(FILT)) dut_i (
        .clk(clk), .rst(rst),
        .ser_clk_i(ser_clk), .ser_data_i(ser_data), .ser_le_i(ser_le),
        .reg_words_o(words), .reg_upd_o(upd), .frame_err_o(err)
    );

    always #(CLK_P/2) clk = ~clk;

    int n_chk = 0, n_fail = 0, n_strobe = 0;
    bit done = 1'b0, mon_en = 1'b0;
    logic [PW-1:0] exp_regs [NR];
    logic [NR-1:0] exp_upd = '0;
    logic          exp_err = 1'b0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, expv, $time);
        end
    endtask

    // reference model compared on every clock
    initial forever begin
        @(posedge clk);
        #(CLK_P/4);
        if (mon_en) begin
            for (int i = 0; i < NR; i++)
                chk(words[i*PW +: PW] == exp_regs[i], "R3 word", 64'(words[i*PW +: PW]), 64'(exp_regs[i]));
            chk(upd == exp_upd, "R4 strobe", 64'(upd), 64'(exp_upd));
            chk(err == exp_err, "R6 err", 64'(err), 64'(exp_err));
            chk(($countones(upd) <= 1) && !(err && |upd), "R9 exclusive", 64'({err, upd}), 64'(0));
            if (|upd) n_strobe++;
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bits(input logic [31:0] w, input int n, input bit glitch);
        for (int b = n - 1; b >= 0; b--) begin
            ser_data = w[b];
            wait_cyc(HP);
            ser_clk = 1'b1;
            wait_cyc(HP);
            ser_clk = 1'b0;
            if (glitch && b == 12) begin
                wait_cyc(HP);
                ser_clk = 1'b1;       // R8: one-cycle spike, shorter than FILT
                wait_cyc(1);
                ser_clk = 1'b0;
            end
        end
        wait_cyc(HP);
    endtask

    task automatic pulse_le(input int hold, input bit good, input int addr, input logic [PW-1:0] pl);
        ser_le = 1'b1;
        repeat (FILT + 3) @(posedge clk);
        if (good) begin
            exp_regs[addr] = pl;
            exp_upd = NR'(1) << addr;
        end else begin
            exp_err = 1'b1;
        end
        @(posedge clk);
        exp_upd = '0;
        exp_err = 1'b0;
        @(negedge clk);
        wait_cyc(hold);
        ser_le = 1'b0;
        wait_cyc(HP + FILT + 3);
    endtask

    task automatic write_frame(input int addr, input logic [PW-1:0] pl, input int hold, input bit glitch);
        send_bits({10'd0, pl, 2'(addr)}, FRAME_W, glitch);
        pulse_le(hold, 1'b1, addr, pl);
        chk(words[addr*PW +: PW] == pl, "R2 payload decode", 64'(words[addr*PW +: PW]), 64'(pl));
    endtask

    initial begin
        int s0;
        for (int i = 0; i < NR; i++) exp_regs[i] = '0;
        wait_cyc(4);
        rst = 1'b0;
        wait_cyc(1);
        // R1: reset state
        chk(words == '0, "R1 words", 64'(words[63:0]), 64'(0));
        chk(upd == '0 && err == 1'b0, "R1 strobes", 64'({err, upd}), 64'(0));
        mon_en = 1'b1;

        // R2 R3 R4: every address, distinct patterns
        write_frame(0, 22'h2A5A5A, 2, 1'b0);
        write_frame(1, 22'h15C3F0, 2, 1'b0);
        write_frame(2, 22'h3FFFFF, 2, 1'b0);
        write_frame(3, 22'h000001, 2, 1'b0);
        write_frame(2, 22'h000000, 2, 1'b0);

        // R5: long LE pulse gives exactly one strobe
        s0 = n_strobe;
        write_frame(1, 22'h0ABCDE, 40, 1'b0);
        chk(n_strobe == s0 + 1, "R5 single load", 64'(n_strobe - s0), 64'd1);

        // R6: short and long frames rejected
        send_bits(32'h00FFFFFF, 20, 1'b0);
        pulse_le(2, 1'b0, 0, '0);
        send_bits(32'h03FFFFFD, 26, 1'b0);
        pulse_le(2, 1'b0, 0, '0);
        chk(words[1*PW +: PW] == 22'h0ABCDE, "R6 words held", 64'(words[1*PW +: PW]), 64'h0ABCDE);

        // R7: good frame right after a rejected one
        write_frame(3, 22'h1234AB, 2, 1'b0);

        // R8: clock glitch inside a frame is ignored
        write_frame(0, 22'h155555, 2, 1'b1);

        // R8: LE glitch neither loads nor restarts the count
        s0 = n_strobe;
        send_bits({10'd0, 22'h2DEAD1, 2'd2}, FRAME_W, 1'b0);
        ser_le = 1'b1;
        wait_cyc(1);
        ser_le = 1'b0;
        wait_cyc(HP + FILT + 4);
        chk(n_strobe == s0 && words[2*PW +: PW] == 22'h000000, "R8 LE glitch", 64'(n_strobe - s0), 64'd0);
        pulse_le(2, 1'b1, 2, 22'h2DEAD1);
        chk(words[2*PW +: PW] == 22'h2DEAD1, "R8 count kept", 64'(words[2*PW +: PW]), 64'h2DEAD1);

        wait_cyc(10);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule